// File: doc/BRIEF.md
# Searchable Shift-Register Queue

This block is a very shallow queue of fixed-width entries, one or two deep. Besides the usual push, pop, head view and flush, it has a combinational lookup port. The lookup answers one question: does any live entry satisfy a match rule against a key? An issue stage uses it to stall a new operation while an older queued operation will still write one of that operation's source registers. Storage is a plain shift register. Slot 0 is always the head. A pop moves slot 1 down into slot 0.

Within one cycle the operations act in a fixed order: the head is viewed first, then pop or flush, then lookup, then push. The lookup therefore already sees the effect of a same-cycle pop or flush. Push readiness is also judged after a same-cycle pop. A flush wins over a same-cycle push.

Entries have a kind field in the top two bits: 00 add, 01 branch, 10 load, 11 store. The destination field is the low KEY_W bits. The match rule is chosen at elaboration time by parameter MATCH_KIND:
- 0 (the default): the entry must be an add or a load, and its destination must equal the key.
- 1: the low field is compared with the key, whatever the kind.

Top module: `sfifo_srch`

## Requirements
- R1: After reset the queue is empty: head_valid=0, deq_ready=0, enq_ready=1 and srch_hit=0.
- R2: enq_ready is 1 exactly when clear is low and the last slot is empty once this cycle's pop has taken effect. A push with enq_ready low changes nothing.
- R3: Pushed entries leave in the order they were pushed. A push fills the lowest slot that is empty after this cycle's pop.
- R4: deq_ready equals "slot 0 holds an entry". A pop with deq_ready high removes the head and moves slot 1 into slot 0.
- R5: head_valid and head_data show slot 0 as it was at the start of the cycle, before any same-cycle pop, flush or push.
- R6: clear empties every slot, and a push in the same cycle is dropped. The queue is empty on the next cycle.
- R7: srch_hit is 1 exactly when some entry still present after this cycle's pop or flush satisfies the match rule against srch_key. Empty slots never match.
- R8: With MATCH_KIND=0, an entry of kind 00 (add) or 10 (load) matches when its low KEY_W bits equal the key. Kinds 01 (branch) and 11 (store) never match.
- R9: On a full two-entry queue, a pop and a push in the same cycle are both accepted. The old second entry becomes the head, and the new entry sits behind it.
- R10: A pop on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Push request |
| enq_data | input | DATA_W | Entry to push |
| enq_ready | output | 1 | Push will be accepted this cycle |
| deq_valid | input | 1 | Pop request |
| deq_ready | output | 1 | Queue not empty, so a pop is allowed |
| head_valid | output | 1 | Slot 0 holds an entry |
| head_data | output | DATA_W | Content of slot 0 |
| clear | input | 1 | Flush all entries |
| srch_key | input | KEY_W | Lookup key |
| srch_hit | output | 1 | Some surviving entry matches the key |

## Verification
The assertions check several properties on every cycle:
- the lookup never reports a hit while the queue is empty or being flushed;
- a flush always leaves the queue empty;
- a push into an empty queue appears at the head one cycle later;
- the head holds its value while no pop or flush is requested.

The ordering of entries, the exact readiness under a same-cycle pop, and the kind-based match rule need the bench's queue model. That model is compared on every clock through scenarios: full queue with pop and push together, flush with push, lookup during a pop, and pop on an empty queue.

// File: rtl/sfifo_srch.sv
module sfifo_srch #(
  parameter int DEPTH      = 2,
  parameter int DATA_W     = 16,
  parameter int KEY_W      = 5,
  parameter int MATCH_KIND = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [DATA_W-1:0] enq_data,
  output logic              enq_ready,
  input  logic              deq_valid,
  output logic              deq_ready,
  output logic              head_valid,
  output logic [DATA_W-1:0] head_data,
  input  logic              clear,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              srch_hit
);
  localparam logic [1:0] KIND_ADD  = 2'b00;
  localparam logic [1:0] KIND_LOAD = 2'b10;

  logic [DEPTH-1:0]  vld;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  pv;
  logic [DATA_W-1:0] pd [DEPTH];
  logic [DEPTH-1:0]  enq_sel;
  logic [DEPTH-1:0]  hit_vec;
  logic              deq_fire;
  logic              enq_fire;

  function automatic logic slot_match(input logic [DATA_W-1:0] e, input logic [KEY_W-1:0] k);
    logic [1:0] kind;
    kind = e[DATA_W-1 -: 2];
    if (MATCH_KIND == 0)
      return (kind == KIND_ADD || kind == KIND_LOAD) && (e[KEY_W-1:0] == k);
    else
      return e[KEY_W-1:0] == k;
  endfunction

  assign deq_fire   = deq_valid & vld[0];
  assign enq_ready  = ~clear & ~pv[DEPTH-1];
  assign enq_fire   = enq_valid & enq_ready;
  assign deq_ready  = vld[0];
  assign head_valid = vld[0];
  assign head_data  = mem[0];
  assign srch_hit   = |hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i + 1 < DEPTH) begin : g_mid
      assign pv[i] = ~clear & (deq_fire ? vld[i+1] : vld[i]);
      assign pd[i] = deq_fire ? mem[i+1] : mem[i];
    end else begin : g_last
      assign pv[i] = ~clear & ~deq_fire & vld[i];
      assign pd[i] = mem[i];
    end

    if (i == 0) begin : g_first
      assign enq_sel[i] = enq_fire & ~pv[i];
    end else begin : g_rest
      assign enq_sel[i] = enq_fire & ~pv[i] & pv[i-1];
    end

    assign hit_vec[i] = pv[i] & slot_match(pd[i], srch_key);

    always_ff @(posedge clk) begin
      if (!rst_n) vld[i] <= 1'b0;
      else        vld[i] <= pv[i] | enq_sel[i];
    end

    always_ff @(posedge clk) begin
      if (enq_sel[i]) mem[i] <= enq_data;
      else            mem[i] <= pd[i];
    end
  end
endmodule

// File: rtl/sfifo_srch_chk.sv
module sfifo_srch_chk #(
  parameter int DATA_W = 16,
  parameter int KEY_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_valid,
  input logic [DATA_W-1:0] enq_data,
  input logic              enq_ready,
  input logic              deq_valid,
  input logic              deq_ready,
  input logic              head_valid,
  input logic [DATA_W-1:0] head_data,
  input logic              clear,
  input logic [KEY_W-1:0]  srch_key,
  input logic              srch_hit
);
  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |-> !srch_hit); // R7
  AST_FLUSH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !srch_hit); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !head_valid); // R6
  AST_FLUSH_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !enq_ready); // R2
  AST_PUSH_TO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready && !head_valid) |=> (head_valid && head_data == $past(enq_data))); // R3
  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !deq_valid && !clear) |=> (head_valid && head_data == $past(head_data))); // R5
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    deq_ready == head_valid); // R4
endmodule

bind sfifo_srch sfifo_srch_chk #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_chk (.*);

// File: tb/sfifo_srch_test.sv
module sfifo_srch_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 2;
  localparam int DW     = 16;
  localparam int KW     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, deq_valid = 1'b0, clear = 1'b0;
  logic [DW-1:0] enq_data = '0;
  logic [KW-1:0] srch_key = '0;
  logic enq_ready, deq_ready, head_valid, srch_hit;
  logic [DW-1:0] head_data;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] q[$];

  always #(PERIOD/2) clk = ~clk;

  sfifo_srch #(.DEPTH(DEPTH), .DATA_W(DW), .KEY_W(KW), .MATCH_KIND(0)) uut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_data(enq_data),
    .enq_ready(enq_ready), .deq_valid(deq_valid), .deq_ready(deq_ready),
    .head_valid(head_valid), .head_data(head_data), .clear(clear),
    .srch_key(srch_key), .srch_hit(srch_hit));

  function automatic logic [DW-1:0] ent(input logic [1:0] kind, input logic [KW-1:0] dst, input logic [8:0] pad);
    return {kind, pad, dst};
  endfunction

  function automatic logic mm(input logic [DW-1:0] e, input logic [KW-1:0] k);
    return (e[DW-1:DW-2] == 2'b00 || e[DW-1:DW-2] == 2'b10) && e[KW-1:0] == k;
  endfunction

  task automatic chk(input string req, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s (%s) at %0t: actual=%0h expected=%0h", req, tag, $time, act, expv);
    end
  endtask

  task automatic step(input logic ev, input logic [DW-1:0] ed, input logic dv,
                      input logic cl, input logic [KW-1:0] key, input string tag);
    logic hv, df, er, hit;
    int ps;
    @(negedge clk);
    enq_valid = ev; enq_data = ed; deq_valid = dv; clear = cl; srch_key = key;
    #1;
    hv = q.size() > 0;
    df = dv && hv;
    ps = cl ? 0 : q.size() - (df ? 1 : 0);
    er = !cl && ps < DEPTH;
    hit = 1'b0;
    if (!cl)
      for (int k = (df ? 1 : 0); k < q.size(); k++) if (mm(q[k], key)) hit = 1'b1;
    chk("R5", tag, head_valid, hv);
    if (hv) chk("R5", tag, head_data, q[0]);
    chk("R4", tag, deq_ready, hv);
    chk("R2", tag, enq_ready, er);
    chk("R7", tag, srch_hit, hit);
    @(posedge clk);
    if (cl) q.delete();
    else begin
      if (df) void'(q.pop_front());
      if (ev && er) q.push_back(ed);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "reset", head_valid, 0);
    chk("R1", "reset", deq_ready, 0);
    chk("R1", "reset", enq_ready, 1);
    chk("R1", "reset", srch_hit, 0);

    step(0, '0, 1, 0, 5'd3, "R10 pop on empty");
    step(0, '0, 0, 0, 5'd3, "R10 still empty");
    // R3 ordering and R8 kinds
    step(1, ent(2'b00, 5'd3, 9'h011), 0, 0, 5'd3, "R3 push add");
    step(1, ent(2'b01, 5'd7, 9'h022), 0, 0, 5'd3, "R8 push branch, add hits");
    step(0, '0, 0, 0, 5'd7, "R8 branch dest never hits");
    step(1, ent(2'b10, 5'd9, 9'h033), 0, 0, 5'd9, "R2 push when full refused");
    // R9 pop and push together while full
    step(1, ent(2'b10, 5'd9, 9'h044), 1, 0, 5'd3, "R9 pop+push full, lookup after pop");
    step(0, '0, 0, 0, 5'd9, "R8 load hits");
    step(0, '0, 1, 0, 5'd9, "R9 pop order");
    step(1, ent(2'b11, 5'd4, 9'h055), 0, 0, 5'd4, "R8 store never hits");
    step(1, ent(2'b00, 5'd4, 9'h066), 1, 0, 5'd4, "R7 pop with lookup");
    // R6 flush with push
    step(1, ent(2'b00, 5'd1, 9'h077), 0, 1, 5'd4, "R6 flush drops push");
    step(0, '0, 0, 0, 5'd1, "R6 empty after flush");
    step(1, ent(2'b00, 5'd2, 9'h088), 0, 0, 5'd2, "R3 push after flush");
    step(1, ent(2'b10, 5'd2, 9'h099), 1, 0, 5'd2, "R3 pop+push one entry");
    step(0, '0, 1, 0, 5'd2, "R4 pop last");
    step(0, '0, 0, 0, 5'd2, "R4 empty");

    for (int n = 0; n < 600; n++) begin
      logic [1:0] kd;
      kd = 2'($urandom);
      step(1'($urandom), ent(kd, 5'($urandom_range(0, 3)), 9'($urandom)),
           1'($urandom), ($urandom_range(0, 15) == 0), 5'($urandom_range(0, 3)), "random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule